// File: doc/BRIEF.md
# Time-Aware Gate List Sequencer

This block produces the eight transmit-gate enables for one egress port. Each queue has one gate, and the gates open and close on a repeating time schedule. Software fills a gate control list through a small 16-bit register write port. Each list entry holds two things: how long the current gate pattern lasts, and an 8-bit toggle mask. At the end of the entry's interval the mask is XORed into the gates, which gives the pattern of the next entry. The last entry toggles the gates back to the initial pattern. The schedule also has an initial gate pattern, a cycle length in nanoseconds, and a start instant. The start instant is a nanosecond value plus the seconds count modulo 8.

The block compares the start instant with a free-running time-of-day input. When they match, the armed schedule becomes operational. It then repeats every cycle time until it is replaced or gating is switched off. The list storage has two banks. Writes always go to the bank that is not running, so a running schedule is untouched until the start instant of its successor.

Before any schedule is operational, the port shows a static administrative gate pattern. With gating disabled, every gate is open. Time advances by `TICK_NS` nanoseconds per clock inside the sequencer.

Top module: `tas_gate_seq`

## Requirements
- R1: After a synchronous reset, gating is disabled, `gate_open` is 0xFF and no schedule is armed.
- R2: Control register (address 9): bit 0 enables gating and bits [15:8] hold the admin gate pattern.
  - While gating is enabled and no schedule is operational, `gate_open` shows the admin pattern from the second clock after the write.
  - Clearing bit 0 stops any operational schedule, disarms the pending one, and drives `gate_open` to 0xFF.
  - Enabling again shows the admin pattern; the old schedule does not resume.
- R3: Entries are staged before they are committed:
  - Address 0 stages the toggle mask in [7:0] and the last-entry flag in bit 8.
  - Addresses 1 and 2 stage the low and high halves of the 32-bit interval.
  - A write to address 3 commits the staged entry at list index [15:8] and sets the initial gate pattern to [7:0].
- R4: A commit write whose index [15:8] is DEPTH or more is ignored entirely. No list entry changes and the initial pattern keeps its value.
- R5: Arming uses four timing registers and one command:
  - Addresses 4 and 5 hold the low and high halves of the cycle time.
  - Addresses 6 and 7 hold the low and high halves of the start nanoseconds.
  - A write to address 8 with bits [1:0] = 2'b11 arms the schedule, and bits [4:2] give the start second modulo 8.
- R6: An armed schedule starts at the first clock edge where all of these hold: gating is enabled, `tod_sec_lo` equals the armed seconds field, and `tod_ns` is at least the start nanoseconds. From that edge `gate_open` is the initial pattern and entry 0 is current.
- R7: Each entry's pattern lasts its interval. The sequencer counts `TICK_NS` per clock. When the elapsed time reaches the interval, the entry's mask is XORed into the gates and the next entry becomes current.
- R8: After an entry with the last-entry flag, or after list index DEPTH-1, the sequence continues at entry 0 within the same cycle. The gates are changed only by that entry's mask.
- R9: Once the elapsed time since the start of a cycle reaches the cycle time, the gates reload the initial pattern and entry 0 restarts, even in the middle of an entry.
- R10: A write to address 8 with bits [1:0] other than 2'b11 (for example all zeros) cancels the armed schedule, so it never starts.
- R11: List, initial-pattern and cycle-time writes made while a schedule runs do not change it. It keeps running until the start instant of the next armed schedule, and from that instant the new schedule runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 16 | Register write data |
| tod_ns | input | 32 | Time of day, nanoseconds within the second |
| tod_sec_lo | input | 3 | Time of day, seconds modulo 8 |
| gate_open | output | 8 | Per-queue transmit gate enables, bit i for queue i |

## Verification
A wrong entry index, toggle mask or elapsed count shows on `gate_open` no later than the next entry boundary. The wrong gate pattern then persists for the rest of the cycle, because every later pattern is built by XOR on top of it. A wrong bank pointer or a premature start shows the old or new schedule at the wrong time. A missed cycle restart leaves the pattern misaligned from the cycle boundary onward. The bench therefore compares `gate_open` with a time-based model on every clock. It does so across hand-overs, cancellations, a seconds mismatch and a boundary-violating commit.

// File: rtl/tas_pkg.sv
package tas_pkg;
  localparam int NGATE = 8;
  localparam int IVW   = 32;
  localparam int SECW  = 3;

  typedef logic [NGATE-1:0] gates_t;

  typedef struct packed {
    logic            last;
    gates_t          mask;
    logic [IVW-1:0]  iv;
  } gcl_ent_t;

  typedef enum logic [3:0] {
    RG_ENT_DATA = 4'd0,
    RG_IVL_LO   = 4'd1,
    RG_IVL_HI   = 4'd2,
    RG_COMMIT   = 4'd3,
    RG_CYC_LO   = 4'd4,
    RG_CYC_HI   = 4'd5,
    RG_BASE_LO  = 4'd6,
    RG_BASE_HI  = 4'd7,
    RG_START    = 4'd8,
    RG_CTRL     = 4'd9
  } reg_addr_e;
endpackage

// File: rtl/tas_cfg_regs.sv
module tas_cfg_regs
  import tas_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [3:0]       addr,
  input  logic [15:0]      wdata,
  input  logic             go,
  output logic             cm_we,
  output logic [AW-1:0]    cm_addr,
  output gcl_ent_t         cm_ent,
  output gates_t           adm_init,
  output logic [IVW-1:0]   adm_cyc,
  output logic [31:0]      base_ns,
  output logic [SECW-1:0]  base_sec,
  output logic             armed,
  output logic             gate_en,
  output gates_t           admin_gates
);
  reg_addr_e      a_e;
  logic           in_rng;
  gates_t         stg_mask;
  logic           stg_last;
  logic [IVW-1:0] stg_iv;

  assign a_e    = reg_addr_e'(addr);
  assign in_rng = {24'd0, wdata[15:8]} < 32'(DEPTH);

  // commit port toward the list storage: staged fields at the time of the write
  assign cm_we   = we && (a_e == RG_COMMIT) && in_rng;
  assign cm_addr = wdata[8 +: AW];
  assign cm_ent  = '{last: stg_last, mask: stg_mask, iv: stg_iv};

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_mask    <= '0;
      stg_last    <= 1'b0;
      stg_iv      <= '0;
      adm_init    <= '1;
      adm_cyc     <= '0;
      base_ns     <= '0;
      base_sec    <= '0;
      armed       <= 1'b0;
      gate_en     <= 1'b0;
      admin_gates <= '1;
    end else begin
      if (go) armed <= 1'b0;
      if (we) begin
        case (a_e)
          RG_ENT_DATA: begin
            stg_mask <= wdata[7:0];
            stg_last <= wdata[8];
          end
          RG_IVL_LO:  stg_iv[15:0]   <= wdata;
          RG_IVL_HI:  stg_iv[31:16]  <= wdata;
          RG_COMMIT:  if (in_rng) adm_init <= wdata[7:0];
          RG_CYC_LO:  adm_cyc[15:0]  <= wdata;
          RG_CYC_HI:  adm_cyc[31:16] <= wdata;
          RG_BASE_LO: base_ns[15:0]  <= wdata;
          RG_BASE_HI: base_ns[31:16] <= wdata;
          RG_START: begin
            armed    <= (wdata[1:0] == 2'b11);
            base_sec <= wdata[4:2];
          end
          RG_CTRL: begin
            gate_en     <= wdata[0];
            admin_gates <= wdata[15:8];
            if (!wdata[0]) armed <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  // R10: a start command without both arm bits leaves nothing armed
  a_r10_cancel: assert property (@(posedge clk) disable iff (rst)
    (we && a_e == RG_START && wdata[1:0] != 2'b11) |=> !armed);

  // R5: a start command with both arm bits arms the schedule
  a_r5_arm: assert property (@(posedge clk) disable iff (rst)
    (we && a_e == RG_START && wdata[1:0] == 2'b11) |=> armed);

  // R2: turning gating off also disarms
  a_r2_off_disarm: assert property (@(posedge clk) disable iff (rst)
    (we && a_e == RG_CTRL && !wdata[0]) |=> (!armed && !gate_en));
endmodule

// File: rtl/tas_gcl_ram.sv
module tas_gcl_ram
  import tas_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic          wbank,
  input  logic [AW-1:0] waddr,
  input  gcl_ent_t      wdata,
  input  logic          rbank,
  input  logic [AW-1:0] raddr,
  output gcl_ent_t      rdata
);
  localparam int BW = $bits(gcl_ent_t);

  logic [BW-1:0] rd [2];

  // one storage array per bank; the running bank is only read
  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [BW-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we && wbank == 1'(b)) mem[waddr] <= wdata;
    end
    assign rd[b] = mem[raddr];
  end

  assign rdata = gcl_ent_t'(rbank ? rd[1] : rd[0]);
endmodule

// File: rtl/tas_seq_engine.sv
module tas_seq_engine
  import tas_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int AW      = 4,
  parameter int TICK_NS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  gates_t          admin_gates,
  input  logic            armed,
  input  logic [31:0]     base_ns,
  input  logic [SECW-1:0] base_sec,
  input  gates_t          adm_init,
  input  logic [IVW-1:0]  adm_cyc,
  input  logic [31:0]     tod_ns,
  input  logic [SECW-1:0] tod_sec_lo,
  input  gcl_ent_t        ent,
  output logic            go,
  output logic            oper_bank,
  output logic [AW-1:0]   idx,
  output gates_t          gate_q
);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic           running;
  logic [IVW-1:0] ent_cnt, cyc_cnt, cyc_len;
  gates_t         init_q;
  logic [IVW:0]   cyc_nx, ent_nx;
  logic           cyc_end, ent_end;

  assign go      = en && armed && (tod_sec_lo == base_sec) && (tod_ns >= base_ns);
  assign cyc_nx  = {1'b0, cyc_cnt} + (IVW+1)'(TICK_NS);
  assign ent_nx  = {1'b0, ent_cnt} + (IVW+1)'(TICK_NS);
  assign cyc_end = cyc_nx >= {1'b0, cyc_len};
  assign ent_end = ent_nx >= {1'b0, ent.iv};

  always_ff @(posedge clk) begin
    if (rst) begin
      running   <= 1'b0;
      oper_bank <= 1'b0;
      idx       <= '0;
      ent_cnt   <= '0;
      cyc_cnt   <= '0;
      cyc_len   <= '0;
      init_q    <= '1;
      gate_q    <= '1;
    end else if (!en) begin
      running <= 1'b0;
      idx     <= '0;
      gate_q  <= '1;
    end else if (go) begin
      running   <= 1'b1;
      oper_bank <= ~oper_bank;
      idx       <= '0;
      ent_cnt   <= '0;
      cyc_cnt   <= '0;
      cyc_len   <= adm_cyc;
      init_q    <= adm_init;
      gate_q    <= adm_init;
    end else if (running) begin
      if (cyc_end) begin
        idx     <= '0;
        ent_cnt <= '0;
        cyc_cnt <= '0;
        gate_q  <= init_q;
      end else if (ent_end) begin
        gate_q  <= gate_q ^ ent.mask;
        idx     <= (ent.last || idx == LAST_IDX) ? '0 : idx + 1'b1;
        ent_cnt <= '0;
        cyc_cnt <= cyc_nx[IVW-1:0];
      end else begin
        ent_cnt <= ent_nx[IVW-1:0];
        cyc_cnt <= cyc_nx[IVW-1:0];
      end
    end else begin
      gate_q <= admin_gates;
    end
  end

  // R2: gating off forces every gate open
  a_r2_off_open: assert property (@(posedge clk) disable iff (rst)
    !en |=> gate_q == 8'hFF);

  // R2: idle while enabled shows the admin pattern
  a_r2_idle_admin: assert property (@(posedge clk) disable iff (rst)
    (en && !running && !go) |=> gate_q == $past(admin_gates));

  // R6: the start edge loads the initial pattern at entry 0
  a_r6_start_init: assert property (@(posedge clk) disable iff (rst)
    go |=> (running && idx == '0 && gate_q == $past(adm_init)));

  // R9: the cycle boundary restarts from the initial pattern
  a_r9_cycle_restart: assert property (@(posedge clk) disable iff (rst)
    (en && running && !go && cyc_end) |=> (idx == '0 && gate_q == init_q));

  // R8: a flagged last entry wraps to entry 0
  a_r8_last_wrap: assert property (@(posedge clk) disable iff (rst)
    (en && running && !go && !cyc_end && ent_end && ent.last) |=> idx == '0);

  // R11: the running bank changes only at a start instant
  a_r11_bank_hold: assert property (@(posedge clk) disable iff (rst)
    !go |=> $stable(oper_bank));
endmodule

// File: rtl/tas_gate_seq.sv
module tas_gate_seq
  import tas_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int TICK_NS = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_we,
  input  logic [3:0]  cfg_addr,
  input  logic [15:0] cfg_wdata,
  input  logic [31:0] tod_ns,
  input  logic [2:0]  tod_sec_lo,
  output logic [7:0]  gate_open
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic            cm_we, armed, gate_en, go, oper_bank;
  logic [AW-1:0]   cm_addr, idx;
  gcl_ent_t        cm_ent, cur_ent;
  gates_t          adm_init, admin_gates, gate_q;
  logic [IVW-1:0]  adm_cyc;
  logic [31:0]     base_ns;
  logic [SECW-1:0] base_sec;

  tas_cfg_regs #(.DEPTH(DEPTH), .AW(AW)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .go(go), .cm_we(cm_we), .cm_addr(cm_addr), .cm_ent(cm_ent),
    .adm_init(adm_init), .adm_cyc(adm_cyc), .base_ns(base_ns),
    .base_sec(base_sec), .armed(armed), .gate_en(gate_en),
    .admin_gates(admin_gates)
  );

  tas_gcl_ram #(.DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk(clk), .we(cm_we), .wbank(~oper_bank), .waddr(cm_addr), .wdata(cm_ent),
    .rbank(oper_bank), .raddr(idx), .rdata(cur_ent)
  );

  tas_seq_engine #(.DEPTH(DEPTH), .AW(AW), .TICK_NS(TICK_NS)) u_seq (
    .clk(clk), .rst(rst), .en(gate_en), .admin_gates(admin_gates),
    .armed(armed), .base_ns(base_ns), .base_sec(base_sec),
    .adm_init(adm_init), .adm_cyc(adm_cyc), .tod_ns(tod_ns),
    .tod_sec_lo(tod_sec_lo), .ent(cur_ent), .go(go),
    .oper_bank(oper_bank), .idx(idx), .gate_q(gate_q)
  );

  assign gate_open = gate_q;
endmodule

// File: tb/sim_tas_gate_seq.sv
module sim_tas_gate_seq;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [31:0] tod_ns = '0;
  logic [2:0]  tod_sec_lo = '0;
  logic [7:0]  gate_open;

  always #10 clk = ~clk;

  tas_gate_seq #(.DEPTH(DEPTH), .TICK_NS(1)) u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .tod_ns(tod_ns), .tod_sec_lo(tod_sec_lo),
    .gate_open(gate_open)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  string ctx = "R1 reset";
  logic [2:0] nsec = '0;

  // reference model, written from the requirements
  logic        m_en = 0, m_armed = 0, m_run = 0, m_slast = 0;
  logic [7:0]  m_admin = 8'hFF, m_ainit = 8'hFF, m_smask = 0, o_init = 0;
  logic [2:0]  m_asec = 0;
  logic [31:0] m_start = 0, m_acyc = 0, m_siv = 0, m_t0 = 0, o_cyc = 1;
  logic [7:0]  a_mask [DEPTH], o_mask [DEPTH];
  logic [31:0] a_iv [DEPTH], o_iv [DEPTH];
  logic        a_last [DEPTH], o_last [DEPTH];
  logic        p_we = 0;
  logic [3:0]  p_a = 0;
  logic [15:0] p_d = 0;
  logic [7:0]  l_st [DEPTH];
  logic [31:0] l_iv [DEPTH];

  function automatic logic [7:0] sched_gate(longint t);
    longint tc, acc;
    int     ix;
    logic [7:0] g;
    tc = t % longint'(o_cyc);
    acc = 0; ix = 0; g = o_init;
    for (int k = 0; k < 4096; k++) begin
      if (acc + longint'(o_iv[ix]) > tc) break;
      acc += longint'(o_iv[ix]);
      g ^= o_mask[ix];
      ix = (o_last[ix] || ix == DEPTH-1) ? 0 : ix + 1;
    end
    return g;
  endfunction

  task automatic step(input bit we, input logic [3:0] a, input logic [15:0] d, input bit chk);
    logic [7:0] exp;
    @(posedge clk);
    #5;
    if (m_en && m_armed && tod_sec_lo == m_asec && tod_ns >= m_start) begin
      for (int i = 0; i < DEPTH; i++) begin
        o_mask[i] = a_mask[i]; o_iv[i] = a_iv[i]; o_last[i] = a_last[i];
      end
      o_init = m_ainit; o_cyc = m_acyc; m_t0 = tod_ns; m_run = 1; m_armed = 0;
    end
    exp = !m_en ? 8'hFF : (m_run ? sched_gate(longint'(tod_ns - m_t0)) : m_admin);
    if (p_we) begin
      case (p_a)
        4'd0: begin m_smask = p_d[7:0]; m_slast = p_d[8]; end
        4'd1: m_siv[15:0] = p_d;
        4'd2: m_siv[31:16] = p_d;
        4'd3: if (int'(p_d[15:8]) < DEPTH) begin
                a_mask[p_d[15:8]] = m_smask; a_iv[p_d[15:8]] = m_siv;
                a_last[p_d[15:8]] = m_slast; m_ainit = p_d[7:0];
              end
        4'd4: m_acyc[15:0] = p_d;
        4'd5: m_acyc[31:16] = p_d;
        4'd6: m_start[15:0] = p_d;
        4'd7: m_start[31:16] = p_d;
        4'd8: begin m_armed = (p_d[1:0] == 2'b11); m_asec = p_d[4:2]; end
        4'd9: begin
                m_en = p_d[0]; m_admin = p_d[15:8];
                if (!p_d[0]) begin m_armed = 0; m_run = 0; end
              end
        default: ;
      endcase
    end
    if (chk && !done) begin
      n_cmp++;
      if (gate_open !== exp) begin
        n_bad++;
        $display("FAIL %s: gate_open=%h expected=%h (tod_ns=%0d)", ctx, gate_open, exp, tod_ns);
      end
    end
    cfg_we = we; cfg_addr = a; cfg_wdata = d;
    p_we = we; p_a = a; p_d = d;
    tod_ns = tod_ns + 32'd1;
    tod_sec_lo = nsec;
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    step(1'b1, a, d, 1'b1);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 4'd0, 16'd0, 1'b1);
  endtask

  task automatic load_sched(input int n, input logic [7:0] init, input logic [31:0] cyc);
    logic [7:0] cur, nxt;
    for (int i = 0; i < n; i++) begin
      cur = (i == 0) ? init : l_st[i];
      nxt = (i == n-1) ? init : l_st[i+1];
      wr(4'd0, {7'd0, (i == n-1), cur ^ nxt});
      wr(4'd1, l_iv[i][15:0]);
      wr(4'd2, l_iv[i][31:16]);
      wr(4'd3, {8'(i), init});
    end
    wr(4'd4, cyc[15:0]);
    wr(4'd5, cyc[31:16]);
  endtask

  task automatic arm(input int lead, input logic [2:0] sec);
    logic [31:0] s;
    s = tod_ns + 32'(lead);
    wr(4'd6, s[15:0]);
    wr(4'd7, s[31:16]);
    wr(4'd8, {11'd0, sec, 2'b11});
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int n, sum;
    logic [7:0] init;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #5 rst = 1'b0;

    ctx = "R1 reset state"; idle(2);
    ctx = "R2 admin pattern"; wr(4'd9, 16'h3C01); idle(4);

    // R3 R4 R5 R7 R8: three entries, cycle longer than the list
    ctx = "R3 R5 R7 R8 list stepping";
    l_st[1] = 8'h0F; l_st[2] = 8'hF0;
    l_iv[0] = 3; l_iv[1] = 5; l_iv[2] = 4;
    load_sched(3, 8'h81, 32'd20);
    ctx = "R4 out-of-range commit";
    wr(4'd0, 16'h01FF); wr(4'd1, 16'd1); wr(4'd2, 16'd0); wr(4'd3, {8'd16, 8'h55});
    ctx = "R6 R7 R8 start and wrap"; arm(10, 3'd0); idle(70);

    // R9 R11: cycle shorter than the list, handed over from the running one
    ctx = "R9 R11 cycle cut";
    l_st[1] = 8'h01; l_st[2] = 8'h80;
    l_iv[0] = 4; l_iv[1] = 4; l_iv[2] = 6;
    load_sched(3, 8'h3C, 32'd9);
    arm(12, 3'd0); idle(50);

    // R10: arm then cancel, running schedule continues past the start instant
    ctx = "R10 cancel";
    l_st[1] = 8'hFF; l_iv[0] = 2; l_iv[1] = 3;
    load_sched(2, 8'h00, 32'd5);
    arm(20, 3'd0); idle(3); wr(4'd8, 16'h0000); idle(30);

    // R6: seconds field must match
    ctx = "R6 seconds mismatch"; arm(8, 3'd1); idle(20);
    ctx = "R6 seconds match"; nsec = 3'd1; idle(25);

    // R11 with random schedules, each replacing the previous
    for (int r = 0; r < 12; r++) begin
      ctx = "R11 R7 R9 random hand-over";
      n = 1 + int'($urandom % 6);
      init = 8'($urandom);
      sum = 0;
      for (int i = 0; i < n; i++) begin
        l_st[i] = 8'($urandom);
        l_iv[i] = 32'(1 + $urandom % 10);
        sum += int'(l_iv[i]);
      end
      load_sched(n, init, 32'(2 + int'($urandom % 32'(sum + 8))));
      arm(6 + int'($urandom % 20), 3'd1);
      idle(30 + 3 * (sum + 10));
    end

    ctx = "R2 disable"; wr(4'd9, 16'h0000); idle(4);
    ctx = "R2 re-enable no resume"; wr(4'd9, 16'h5A01); idle(5);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule